// File: doc/BRIEF.md
# Latched and Real-Time Status Interrupt Unit

This block is the status and interrupt register unit of a packet controller. It holds one status byte in which each bit position is fixed, at build time, as either a latched bit or a real-time bit. Real-time positions show the live level of their condition input, such as a FIFO fill level above a watermark. Latched positions capture the rising edge of their condition input, such as an overrun or an end of packet, and keep it until the host clears it.

A mask register sits beside the status register. Each latched bit reaches the single active-low interrupt output only when its mask bit is set. The host reaches both registers through a one-bit address, a write strobe and write data. Read data is always present and follows the address.

The host clears latched bits by writing a 1 to each position it wants cleared. A cleared bit stays clear until its condition rises again. The interrupt output is registered, so it settles one clock after the latched and mask state that drives it.

Top module: `stat_irq_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, every latched status bit reads 0, every mask bit reads 0 (blocked), and `irq_n_o` is 1.
- R2: With `host_addr_i` = 0, each real-time position of `host_rdata_o` (positions where parameter `LATCHED` holds 0, default 8'hB6) equals the current value of the matching bit of `cond_i`, with no clock of delay.
- R3: A latched bit becomes 1 on the clock edge at which its `cond_i` bit is 1 and was 0 at the previous edge. It then holds 1 until a clearing write, whether or not the condition stays high.
- R4: A write with `host_addr_i` = 0 clears each latched bit whose `host_wdata_i` bit is 1. Bits written with 0 keep their value.
- R5: Writes to address 0 have no effect on real-time positions. After such a write, those positions still read the live `cond_i` value.
- R6: A condition that stays high after its latched bit was cleared does not set that bit again. Only a new 0-to-1 transition sets it.
- R7: When a rising condition and a clearing write reach the same latched bit at the same edge, the bit ends up set.
- R8: A write with `host_addr_i` = 1 loads the mask register from `host_wdata_i`. The mask reads back at address 1. A latched bit whose mask bit is 0 never pulls `irq_n_o` low. Real-time positions never drive the interrupt.
- R9: `irq_n_o` at each edge is the inverse of "some latched bit is 1 with its mask bit 1" as it stood before that edge. It therefore goes low one clock after an unmasked bit sets, and returns high one clock after the last such bit clears or is masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cond_i | input | W | Condition levels from the datapath, one per status position |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 1 | Register select: 0 status, 1 mask |
| host_wdata_i | input | W | Host write data (clear pattern or mask value) |
| host_rdata_o | output | W | Read data of the selected register |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
A latched bit that is stuck or lost shows up on the status read at the first edge after the disturbing event. The same fault reaches `irq_n_o` one clock later, but only if the bit is unmasked. A fault in the edge detector shows as a bit that sets again while its condition is held high after a clear. A real-time position that takes in host writes shows on the very next read, once its condition level differs from the written value. The bench compares both outputs against a reference on every cycle, so any of these faults is reported at the cycle it first becomes visible.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int STAT_W = 8;
    localparam logic [STAT_W-1:0] DEF_LATCHED = 8'hB6;

    typedef enum logic [0:0] {
        REG_STATUS = 1'b0,
        REG_MASK   = 1'b1
    } host_reg_e;

    typedef struct packed {
        logic      wr;
        host_reg_e sel;
    } host_cmd_t;

    function automatic logic hits(input host_cmd_t c, input host_reg_e r);
        return c.wr && (c.sel == r);
    endfunction

    function automatic logic [STAT_W-1:0] status_view(
        input logic [STAT_W-1:0] lat,
        input logic [STAT_W-1:0] live,
        input logic [STAT_W-1:0] kind);
        return (lat & kind) | (live & ~kind);
    endfunction

endpackage

// File: rtl/stat_edge_detect.sv
module stat_edge_detect #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/stat_latch_bank.sv
module stat_latch_bank #(
    parameter int W = 8,
    parameter logic [W-1:0] KIND = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] lat_o
);
    logic [W-1:0] lat_q;

    // a set beats a clear on the same bit (R7)
    always_ff @(posedge clk_i) begin
        if (rst_i) lat_q <= '0;
        else       lat_q <= ((lat_q & ~clr_i) | set_i) & KIND;
    end

    assign lat_o = lat_q;
endmodule

// File: rtl/stat_irq_gen.sv
module stat_irq_gen #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] lat_i,
    input  logic [W-1:0] en_i,
    output logic         irq_n_o
);
    logic irq_n_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) irq_n_q <= 1'b1;
        else       irq_n_q <= ~|(lat_i & en_i);
    end

    assign irq_n_o = irq_n_q;
endmodule

// File: rtl/stat_irq_unit.sv
module stat_irq_unit
    import stat_pkg::*;
#(
    parameter int W = STAT_W,
    parameter logic [W-1:0] LATCHED = DEF_LATCHED
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] cond_i,
    input  logic         host_wr_i,
    input  logic         host_addr_i,
    input  logic [W-1:0] host_wdata_i,
    output logic [W-1:0] host_rdata_o,
    output logic         irq_n_o
);
    host_cmd_t    cmd;
    logic [W-1:0] rise;
    logic [W-1:0] clr_vec;
    logic [W-1:0] lat_q;
    logic [W-1:0] mask_q;

    assign cmd.wr  = host_wr_i;
    assign cmd.sel = host_reg_e'(host_addr_i);

    assign clr_vec = hits(cmd, REG_STATUS) ? host_wdata_i : '0;

    stat_edge_detect #(.W(W)) u_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (cond_i),
        .rise_o  (rise)
    );

    stat_latch_bank #(.W(W), .KIND(LATCHED)) u_bank (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .set_i (rise),
        .clr_i (clr_vec),
        .lat_o (lat_q)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i)                   mask_q <= '0;
        else if (hits(cmd, REG_MASK)) mask_q <= host_wdata_i;
    end

    stat_irq_gen #(.W(W)) u_irq (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .lat_i   (lat_q),
        .en_i    (mask_q),
        .irq_n_o (irq_n_o)
    );

    always_comb begin
        if (cmd.sel == REG_MASK) host_rdata_o = mask_q;
        else                     host_rdata_o = status_view(lat_q, cond_i, LATCHED);
    end
endmodule

// File: rtl/stat_irq_unit_chk.sv
module stat_irq_unit_chk #(
    parameter int W = 8,
    parameter logic [W-1:0] LATCHED = '1
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic [W-1:0] cond_i,
    input logic         host_wr_i,
    input logic         host_addr_i,
    input logic [W-1:0] host_wdata_i,
    input logic [W-1:0] host_rdata_o,
    input logic         irq_n_o,
    input logic [W-1:0] lat_q,
    input logic [W-1:0] mask_q
);
    logic [W-1:0] clr_seen;
    assign clr_seen = (host_wr_i && !host_addr_i) ? host_wdata_i : '0;

    AST_RESET_IRQ_HIGH: assert property (@(posedge clk_i)
        $past(rst_i) |-> irq_n_o); // R1

    AST_LIVE_BITS: assert property (@(posedge clk_i) disable iff (rst_i)
        !host_addr_i |-> (((host_rdata_o ^ cond_i) & ~LATCHED) == '0)); // R2

    AST_SET_NEEDS_COND: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (((lat_q & ~$past(lat_q)) & ~$past(cond_i)) == '0)); // R3

    AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((($past(lat_q) & ~$past(clr_seen)) & ~lat_q) == '0)); // R4

    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((lat_q & $past(clr_seen) & ~$past(cond_i)) == '0)); // R4

    AST_IRQ_TRACKS: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (irq_n_o == !$past(|(lat_q & mask_q)))); // R9
endmodule

bind stat_irq_unit stat_irq_unit_chk #(.W(W), .LATCHED(LATCHED)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .cond_i       (cond_i),
    .host_wr_i    (host_wr_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .irq_n_o      (irq_n_o),
    .lat_q        (lat_q),
    .mask_q       (mask_q)
);

// File: tb/stat_irq_unit_tb.sv
module stat_irq_unit_tb_top;
    localparam int W = 8;
    localparam logic [W-1:0] LAT = 8'hB6;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] cond;
    logic         wr;
    logic         addr;
    logic [W-1:0] wdata;
    logic [W-1:0] rdata;
    logic         irq_n;

    int vectors = 0;
    int fails = 0;

    // reference state
    logic [W-1:0] m_lat, m_mask, m_prev;
    logic         m_irq_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    stat_irq_unit #(.W(W), .LATCHED(LAT)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .cond_i       (cond),
        .host_wr_i    (wr),
        .host_addr_i  (addr),
        .host_wdata_i (wdata),
        .host_rdata_o (rdata),
        .irq_n_o      (irq_n)
    );

    task automatic step(input logic [W-1:0] c, input logic w, input logic a,
                        input logic [W-1:0] d, input string tag);
        logic [W-1:0] exp_rd;
        logic [W-1:0] clr;
        @(negedge clk);
        cond = c; wr = w; addr = a; wdata = d;
        #1;
        exp_rd = a ? m_mask : ((m_lat & LAT) | (c & ~LAT));
        vectors++;
        if (rdata !== exp_rd || irq_n !== m_irq_n) begin
            fails++;
            $display("FAIL %s: rdata=%h irq_n=%b expected rdata=%h irq_n=%b",
                     tag, rdata, irq_n, exp_rd, m_irq_n);
        end
        @(posedge clk);
        clr     = (w && !a) ? d : '0;
        m_irq_n = ~|(m_lat & m_mask);
        m_lat   = ((m_lat & ~clr) | (c & ~m_prev)) & LAT;
        if (w && a) m_mask = d;
        m_prev  = c;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cond = '0; wr = 1'b0; addr = 1'b0; wdata = '0;
        m_lat = '0; m_mask = '0; m_prev = '0; m_irq_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state of status, mask and interrupt
        step(8'h00, 0, 0, 8'h00, "R1");
        step(8'h00, 0, 1, 8'h00, "R1");
        // R2: real-time bits 0,3,6 follow cond with no delay
        step(8'h49, 0, 0, 8'h00, "R2");
        step(8'h08, 0, 0, 8'h00, "R2");
        step(8'h41, 0, 0, 8'h00, "R2");
        step(8'h00, 0, 0, 8'h00, "R2");
        // R8: enable bits 1 and 2 only, read back
        step(8'h00, 1, 1, 8'h06, "R8");
        step(8'h00, 0, 1, 8'h00, "R8");
        // R3/R8: masked bit 4 latches, irq stays high
        step(8'h10, 0, 0, 8'h00, "R3");
        step(8'h00, 0, 0, 8'h00, "R3");
        step(8'h00, 0, 0, 8'h00, "R8");
        // R4: clear with zeros elsewhere keeps bit, then clear bit 4
        step(8'h00, 1, 0, 8'hEF, "R4");
        step(8'h00, 1, 0, 8'h10, "R4");
        step(8'h00, 0, 0, 8'h00, "R4");
        // R9/R6: hold bit 1 high, irq low one clock later, clear, no re-latch
        step(8'h02, 0, 0, 8'h00, "R9");
        step(8'h02, 0, 0, 8'h00, "R9");
        step(8'h02, 0, 0, 8'h00, "R9");
        step(8'h02, 1, 0, 8'h02, "R6");
        step(8'h02, 0, 0, 8'h00, "R6");
        step(8'h02, 0, 0, 8'h00, "R6");
        step(8'h00, 0, 0, 8'h00, "R6");
        step(8'h02, 0, 0, 8'h00, "R6");
        step(8'h00, 1, 0, 8'h02, "R9");
        step(8'h00, 0, 0, 8'h00, "R9");
        // R7: rise on bit 2 during its clear write
        step(8'h04, 1, 0, 8'h04, "R7");
        step(8'h04, 0, 0, 8'h00, "R7");
        step(8'h00, 0, 0, 8'h00, "R7");
        // R8: masking off a set bit releases irq
        step(8'h00, 1, 1, 8'h00, "R8");
        step(8'h00, 0, 0, 8'h00, "R8");
        step(8'h00, 1, 0, 8'hFF, "R4");
        // R5: all-ones write leaves live bits following cond
        step(8'h49, 1, 0, 8'hFF, "R5");
        step(8'h49, 0, 0, 8'h00, "R5");
        step(8'h00, 1, 0, 8'h49, "R5");
        step(8'h00, 0, 0, 8'h00, "R5");

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            step(W'($urandom), ($urandom % 3) == 0, 1'($urandom),
                 W'($urandom), "R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule